// File: doc/BRIEF.md
# Locked-Rotor Guard Timer

This block watches a brushless motor for a locked rotor and, once it finds one, protects the motor and its output stage by allowing drive only in short bursts separated by long pauses. It replaces a charge/discharge capacitor with a digital ramp counter. The ramp rises by a fixed step on every prescaled tick. A one-clock rotation pulse, which arrives once per Hall period, returns the ramp to zero. A turning rotor therefore never lets the ramp reach the trip level.

When the ramp reaches the upper level, the guard starts protecting. Drive is cut while the ramp falls slowly to the lower level. Drive is then allowed while the ramp rises quickly back to the upper level, and this repeats with no end. Any rotation pulse ends protection at once. The commutation logic gates its outputs with the drive-enable output. A status output, which behaves like an open-drain transistor that is switched on, reports normal running. The function can be switched off. While it is off, the ramp is held at zero and drive stays enabled.

Top module: `stall_guard`

## Requirements
- R1: After reset, drive_ok and run_sink are 1 and the ramp is zero, so with ticks only, protection starts after exactly ceil(HIGH_LVL/UP_STEP) ticks (30 with defaults).
- R2: With guard_en high and no hall_evt, the clock edge that samples the tripping tick drives run_sink and drive_ok to 0. run_sink never falls in a cycle that follows no tick.
- R3: A hall_evt pulse returns the ramp to zero, so the full trip count of ticks is needed again after it, whatever the count was before.
- R4: In protection, the drive-off interval lasts ceil((HIGH_LVL-LOW_LVL)/DN_STEP) ticks (360 with defaults), and the ramp never drops below LOW_LVL.
- R5: After the off interval, drive_ok stays 1 for ceil((HIGH_LVL-LOW_LVL)/UP_STEP) ticks (20 with defaults), then returns to 0 for another full off interval, and the cycle repeats.
- R6: run_sink stays 0 for the whole protection cycle, in both the on and the off intervals. When run_sink is 1, drive_ok is 1.
- R7: A hall_evt during protection sets run_sink and drive_ok to 1 on the next clock edge.
- R8: With guard_en low, drive_ok and run_sink are 1 from the next edge and the ramp is held at zero, whatever ticks arrive.
- R9: A hall_evt in the same cycle as a tick wins: the ramp goes to zero.
- R10: In a cycle with no tick and no hall_evt and with guard_en high, the outputs and the ramp do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| guard_en | input | 1 | 1 enables the guard, 0 keeps drive on permanently |
| tick | input | 1 | One-clock prescaled timebase strobe |
| hall_evt | input | 1 | One-clock pulse for each Hall period |
| drive_ok | output | 1 | 1 allows the commutation outputs to drive |
| run_sink | output | 1 | Status: 1 (sinking) while running normally, 0 while protecting |

## Verification
The states hardest to reach are the later ones in the retry cycle, such as the second off interval and a rotation pulse that lands inside the on burst. They lie hundreds of ticks deep and can be seen only through two output bits. The bench walks the whole cycle by counting ticks between output edges and compares each count with a ceiling division of the level parameters. It sweeps the position of the clearing pulse over every tick before the trip, and it repeats the trip count with one, two and three cycles between ticks.

// File: rtl/stall_guard_pkg.sv
// Shared types for the locked-rotor guard.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package stall_guard_pkg;
    // Guard phases: watching for a stall, cooling with drive off, retry burst.
    typedef enum logic [1:0] {
        PH_WATCH = 2'd0,
        PH_COOL  = 2'd1,
        PH_RETRY = 2'd2
    } guard_phase_e;
endpackage

// File: rtl/sg_ramp.sv
// Saturating up/down ramp that stands in for a timing capacitor.
// It steps up by UP_STEP and down by DN_STEP, clamps at HIGH_LVL when rising
// and at LOW_LVL when falling, and flags when the requested step reaches a clamp.
// Assumes that at most one of clr/up/dn is acted on (clr has priority).
module sg_ramp #(
    parameter int unsigned LVL_W    = 10,
    parameter int unsigned LOW_LVL  = 180,
    parameter int unsigned HIGH_LVL = 540,
    parameter int unsigned UP_STEP  = 18,
    parameter int unsigned DN_STEP  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             up,
    input  logic             dn,
    output logic [LVL_W-1:0] level,
    output logic             reach_top,
    output logic             reach_bot
);
    localparam logic [LVL_W-1:0] HIGH_V = LVL_W'(HIGH_LVL);
    localparam logic [LVL_W-1:0] LOW_V  = LVL_W'(LOW_LVL);
    localparam logic [LVL_W-1:0] UP_V   = LVL_W'(UP_STEP);
    localparam logic [LVL_W-1:0] DN_V   = LVL_W'(DN_STEP);
    localparam logic [LVL_W-1:0] BOT_V  = LVL_W'(LOW_LVL + DN_STEP);

    logic [LVL_W-1:0] sum_up;

    // Next value for a rising step and the two clamp detectors.
    always_comb begin
        sum_up    = level + UP_V;
        reach_top = (sum_up >= HIGH_V);
        reach_bot = (level <= BOT_V);
    end

    // Ramp register: clear, saturating rise or saturating fall.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            level <= '0;
        end else if (up) begin
            level <= reach_top ? HIGH_V : sum_up;
        end else if (dn) begin
            level <= reach_bot ? LOW_V : (level - DN_V);
        end
    end
endmodule

// File: rtl/sg_phase.sv
// Phase sequencer of the locked-rotor guard.
// It decides from the ramp clamp flags whether the guard is watching, cooling
// with drive off or in a retry burst, and sends step commands to the ramp.
// Assumes the ramp reports reach flags for the step it is being asked to take.
module sg_phase
    import stall_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         guard_en,
    input  logic         tick,
    input  logic         hall_evt,
    input  logic         reach_top,
    input  logic         reach_bot,
    output logic         clr,
    output logic         up,
    output logic         dn,
    output guard_phase_e phase
);
    guard_phase_e phase_nx;

    // Step commands: a rotation event or a disable clears, otherwise ticks step.
    always_comb begin
        clr = !guard_en || hall_evt;
        up  = !clr && tick && (phase != PH_COOL);
        dn  = !clr && tick && (phase == PH_COOL);
    end

    // Next phase from the step taken and whether it hits a clamp.
    always_comb begin
        phase_nx = phase;
        if (clr) begin
            phase_nx = PH_WATCH;
        end else if (up && reach_top) begin
            phase_nx = PH_COOL;
        end else if (dn && reach_bot) begin
            phase_nx = PH_RETRY;
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_WATCH;
        end else begin
            phase <= phase_nx;
        end
    end
endmodule

// File: rtl/stall_guard.sv
// Locked-rotor guard timer top.
// It ramps on prescaled ticks, and a Hall-period pulse resets the ramp. When the
// ramp reaches HIGH_LVL it runs a long-off / short-on retry cycle until rotation
// returns. Assumes tick and hall_evt are single-cycle strobes in the clk domain.
module stall_guard
    import stall_guard_pkg::*;
#(
    parameter int unsigned LOW_LVL  = 180,
    parameter int unsigned HIGH_LVL = 540,
    parameter int unsigned UP_STEP  = 18,
    parameter int unsigned DN_STEP  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic guard_en,
    input  logic tick,
    input  logic hall_evt,
    output logic drive_ok,
    output logic run_sink
);
    localparam int unsigned LVL_W = $clog2(HIGH_LVL + UP_STEP + 1);

    logic             ramp_clr;
    logic             ramp_up;
    logic             ramp_dn;
    logic             ramp_top;
    logic             ramp_bot;
    logic [LVL_W-1:0] ramp_lvl;
    guard_phase_e     phase;

    sg_ramp #(
        .LVL_W   (LVL_W),
        .LOW_LVL (LOW_LVL),
        .HIGH_LVL(HIGH_LVL),
        .UP_STEP (UP_STEP),
        .DN_STEP (DN_STEP)
    ) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ramp_clr),
        .up       (ramp_up),
        .dn       (ramp_dn),
        .level    (ramp_lvl),
        .reach_top(ramp_top),
        .reach_bot(ramp_bot)
    );

    sg_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .guard_en (guard_en),
        .tick     (tick),
        .hall_evt (hall_evt),
        .reach_top(ramp_top),
        .reach_bot(ramp_bot),
        .clr      (ramp_clr),
        .up       (ramp_up),
        .dn       (ramp_dn),
        .phase    (phase)
    );

    // Output decode: drive is cut only while cooling, status only while watching.
    always_comb begin
        drive_ok = (phase != PH_COOL);
        run_sink = (phase == PH_WATCH);
    end
endmodule

// File: rtl/stall_guard_chk.sv
// Assertion checker for stall_guard, attached with bind below.
// Assumes the ramp level signal of the top is visible by name.
module stall_guard_chk #(
    parameter int unsigned LVL_W    = 10,
    parameter int unsigned LOW_LVL  = 180,
    parameter int unsigned HIGH_LVL = 540
) (
    input logic             clk,
    input logic             rst_n,
    input logic             guard_en,
    input logic             tick,
    input logic             hall_evt,
    input logic             drive_ok,
    input logic             run_sink,
    input logic [LVL_W-1:0] ramp_lvl
);
    // R1
    ramp_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_lvl <= LVL_W'(HIGH_LVL));

    // R2
    trip_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_sink) |-> $past(tick));

    // R4
    ramp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_sink |-> ramp_lvl >= LVL_W'(LOW_LVL));

    // R6
    run_implies_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_sink |-> drive_ok);

    // R7
    hall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hall_evt |=> (run_sink && drive_ok && ramp_lvl == '0));

    // R8
    disabled_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !guard_en |=> (drive_ok && run_sink && ramp_lvl == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_en && !tick && !hall_evt) |=>
            ($stable(drive_ok) && $stable(run_sink) && $stable(ramp_lvl)));
endmodule

bind stall_guard stall_guard_chk #(
    .LVL_W   (LVL_W),
    .LOW_LVL (LOW_LVL),
    .HIGH_LVL(HIGH_LVL)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .guard_en(guard_en),
    .tick    (tick),
    .hall_evt(hall_evt),
    .drive_ok(drive_ok),
    .run_sink(run_sink),
    .ramp_lvl(ramp_lvl)
);

// File: tb/stall_guard_tb.sv
module stall_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LOW_LVL  = 180;
    localparam int HIGH_LVL = 540;
    localparam int UP_STEP  = 18;
    localparam int DN_STEP  = 1;
    localparam int TRIP_T = (HIGH_LVL + UP_STEP - 1) / UP_STEP;
    localparam int ON_T   = (HIGH_LVL - LOW_LVL + UP_STEP - 1) / UP_STEP;
    localparam int OFF_T  = (HIGH_LVL - LOW_LVL + DN_STEP - 1) / DN_STEP;
    localparam int LIMIT  = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic guard_en = 1'b0;
    logic tick = 1'b0;
    logic hall_evt = 1'b0;
    logic drive_ok;
    logic run_sink;

    int n_chk = 0;
    int n_bad = 0;
    bit saw_run;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stall_guard #(
        .LOW_LVL (LOW_LVL),
        .HIGH_LVL(HIGH_LVL),
        .UP_STEP (UP_STEP),
        .DN_STEP (DN_STEP)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .guard_en(guard_en),
        .tick    (tick),
        .hall_evt(hall_evt),
        .drive_ok(drive_ok),
        .run_sink(run_sink)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock: inputs are set at a falling edge, outputs are read at the next falling edge.
    task automatic cyc(input bit t, input bit h);
        tick = t;
        hall_evt = h;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        hall_evt = 1'b0;
    endtask

    task automatic one_tick(input int gap);
        cyc(1'b1, 1'b0);
        for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0);
    endtask

    // Counts ticks until the condition is met: 0 run_sink low, 1 drive_ok high, 2 drive_ok low.
    task automatic count_ticks(input int gap, input int what, output int n);
        bit done;
        n = 0;
        saw_run = 1'b0;
        done = 1'b0;
        while (!done && n < LIMIT) begin
            one_tick(gap);
            n++;
            if (run_sink && what != 0) saw_run = 1'b1;
            case (what)
                0: done = !run_sink;
                1: done = drive_ok;
                default: done = !drive_ok;
            endcase
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        guard_en = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(drive_ok == 1'b1, "R1 drive_ok after reset", int'(drive_ok), 1);
        chk(run_sink == 1'b1, "R1 run_sink after reset", int'(run_sink), 1);

        // R1 R2 trip from a zero ramp, with every tick spacing in the sweep
        for (int gap = 0; gap < 3; gap++) begin
            count_ticks(gap, 0, n);
            chk(n == TRIP_T, "R2 ticks to trip", n, TRIP_T);
            chk(drive_ok == 1'b0, "R2 drive_ok at trip", int'(drive_ok), 0);
            cyc(1'b0, 1'b1);
        end

        // R4 R5 R6 full retry cycle, twice round
        count_ticks(0, 0, n);
        chk(n == TRIP_T, "R1 trip before cycle", n, TRIP_T);
        for (int rep = 0; rep < 2; rep++) begin
            count_ticks(0, 1, n);
            chk(n == OFF_T, "R4 off interval", n, OFF_T);
            chk(!saw_run, "R6 status during off", int'(saw_run), 0);
            count_ticks(0, 2, n);
            chk(n == ON_T, "R5 on interval", n, ON_T);
            chk(!saw_run, "R6 status during on", int'(saw_run), 0);
        end

        // R10 idle cycles in the off interval change nothing
        for (int k = 0; k < 100; k++) one_tick(0);
        for (int k = 0; k < 50; k++) begin
            cyc(1'b0, 1'b0);
            if (drive_ok || run_sink) saw_run = 1'b1;
        end
        chk(drive_ok == 1'b0 && run_sink == 1'b0, "R10 outputs held idle",
            int'(drive_ok) + int'(run_sink), 0);
        count_ticks(0, 1, n);
        chk(n == OFF_T - 100, "R10 off remainder after idle", n, OFF_T - 100);

        // R7 rotation event inside the on burst
        one_tick(0);
        chk(drive_ok == 1'b1 && run_sink == 1'b0, "R7 in on burst",
            int'(run_sink), 0);
        cyc(1'b0, 1'b1);
        chk(run_sink == 1'b1, "R7 run_sink after hall in burst", int'(run_sink), 1);
        chk(drive_ok == 1'b1, "R7 drive_ok after hall in burst", int'(drive_ok), 1);

        // R7 rotation event inside the off interval
        count_ticks(0, 0, n);
        for (int k = 0; k < 7; k++) one_tick(1);
        cyc(1'b0, 1'b1);
        chk(run_sink == 1'b1 && drive_ok == 1'b1, "R7 clear from off",
            int'(run_sink) + int'(drive_ok), 2);

        // R3 sweep of the clearing pulse over every tick position before the trip
        for (int k = 0; k < TRIP_T; k++) begin
            for (int j = 0; j < k; j++) one_tick(0);
            cyc(1'b0, 1'b1);
            count_ticks(0, 0, n);
            chk(n == TRIP_T, $sformatf("R3 trip after clear at %0d", k), n, TRIP_T);
            cyc(1'b0, 1'b1);
        end

        // R9 tick and hall pulse in the same cycle
        for (int j = 0; j < TRIP_T - 1; j++) one_tick(0);
        cyc(1'b1, 1'b1);
        chk(run_sink == 1'b1, "R9 no trip on coincident pulse", int'(run_sink), 1);
        count_ticks(0, 0, n);
        chk(n == TRIP_T, "R9 ramp cleared by coincident pulse", n, TRIP_T);

        // R8 disable in the off interval, ticks ignored, full count after enable
        for (int j = 0; j < 5; j++) one_tick(0);
        guard_en = 1'b0;
        cyc(1'b0, 1'b0);
        chk(drive_ok == 1'b1 && run_sink == 1'b1, "R8 outputs when disabled",
            int'(drive_ok) + int'(run_sink), 2);
        saw_run = 1'b0;
        for (int j = 0; j < 100; j++) begin
            one_tick(0);
            if (!drive_ok || !run_sink) saw_run = 1'b1;
        end
        chk(!saw_run, "R8 ticks ignored when disabled", int'(saw_run), 0);
        guard_en = 1'b1;
        count_ticks(0, 0, n);
        chk(n == TRIP_T, "R8 ramp held at zero while disabled", n, TRIP_T);

        // R1 reset in protection restores the reset state
        rst_n = 1'b0;
        cyc(1'b0, 1'b0);
        rst_n = 1'b1;
        chk(drive_ok == 1'b1 && run_sink == 1'b1, "R1 reset from protection",
            int'(drive_ok) + int'(run_sink), 2);
        count_ticks(0, 0, n);
        chk(n == TRIP_T, "R1 ramp zero after reset", n, TRIP_T);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule